// File: doc/BRIEF.md
# Gshare Global History Direction Predictor

This block predicts whether a conditional branch will be taken. It folds a slice of the branch address together with a short record of recent branch outcomes into one table index. Every branch in the program shares a single history register and a single table of 2-bit saturating counters. The lookup port accepts a 16-bit program counter. In the same cycle, without a clock edge, it returns the table index, the counter found there and the predicted direction.

The fetch logic keeps the index it received for each branch. When the branch resolves, the training port sends that index back with the real outcome. The counter at that index moves one step toward the outcome. At the same clock edge the outcome is shifted into the history. Both ports are valid/ready streams, and both ready signals are held high. There is therefore no back-pressure: every beat offered with valid high is accepted in that cycle. Restoring the history after a misprediction is not part of this block.

Top module: `gshare_predictor`

## Requirements
- R1: The lookup index is program counter bits 7 down to 4 XORed with the 4-bit global history. Bit i of the index is pc[4+i] XOR history[i].
- R2: The lookup output carries the 2-bit counter stored at the lookup index. The predicted direction is that counter's upper bit, where 1 means taken.
- R3: A training beat with the outcome taken (train_taken = 1) raises the counter at train_idx by one at the next edge. A counter already at 11 stays at 11.
- R4: A training beat with the outcome not taken (train_taken = 0) lowers the counter at train_idx by one at the next edge. A counter already at 00 stays at 00.
- R5: Each training beat shifts the history left by one place, and the outcome enters at bit 0, in the same edge as the counter change.
- R6: A lookup and a training beat in the same cycle, both aimed at the same entry, see the counter value from before that training beat.
- R7: A synchronous reset clears the history to 0. It loads every counter from the INIT_TABLE parameter, in which entry e sits at bits [2e+1:2e]. The default sets every counter to 01.
- R8: A training beat changes only the counter at its own index. All other entries keep their values.
- R9: Both ready outputs stay high. A cycle with train_valid low changes neither the history nor any counter, whatever train_idx and train_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookup_valid | input | 1 | Lookup request is present |
| lookup_ready | output | 1 | Lookup accepted; always 1 |
| lookup_pc | input | 16 | Branch address to predict |
| pred_valid | output | 1 | Prediction outputs are meaningful; follows lookup_valid |
| pred_idx | output | 4 | Table index formed for this lookup |
| pred_ctr | output | 2 | Counter value at pred_idx |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| train_valid | input | 1 | Resolved-branch beat is present |
| train_ready | output | 1 | Training accepted; always 1 |
| train_idx | input | 4 | Index returned by the lookup for this branch |
| train_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The counter-step assertions take for granted that train_idx holds a valid 4-bit index and that train_taken is a known value whenever train_valid is high. The stimulus only ever drives indices inside the 16-entry table, with defined outcome bits. The history assertions assume training beats can arrive back to back with no idle cycles between them. The bench also trains at a slower pace, and it presents idle cycles carrying garbage on the index and outcome lines. Two builds, one with the default reset table and one with a known irregular table, both receive the same stimulus. This lets the bench confirm the reset contents and each step of the counters against its own arithmetic model.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;

  localparam int unsigned DEF_PC_W   = 16;
  localparam int unsigned DEF_PC_LSB = 4;
  localparam int unsigned DEF_HIST_W = 4;
  localparam int unsigned DEF_CTR_W  = 2;
endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int unsigned PC_W   = gshare_pkg::DEF_PC_W,
  parameter int unsigned PC_LSB = gshare_pkg::DEF_PC_LSB,
  parameter int unsigned HIST_W = gshare_pkg::DEF_HIST_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);
  logic unused_pc_bits;

  assign unused_pc_bits = ^pc;

  genvar b;
  generate
    for (b = 0; b < HIST_W; b++) begin : g_bit
      assign idx[b] = pc[PC_LSB + b] ^ hist[b];
    end
  endgenerate
endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int unsigned HIST_W = gshare_pkg::DEF_HIST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[HIST_W-2:0], outcome};
    end
  end
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht #(
  parameter int unsigned IDX_W = gshare_pkg::DEF_HIST_W,
  parameter int unsigned CTR_W = gshare_pkg::DEF_CTR_W,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  parameter logic [ENTRIES*CTR_W-1:0] INIT_TABLE = {ENTRIES{2'b01}}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_up,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [CTR_W-1:0]         rd_ctr,
  output logic [ENTRIES*CTR_W-1:0] tab_flat
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_entry
      logic [CTR_W-1:0] ctr_q;
      logic             hit;

      assign hit = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
        if (rst) begin
          ctr_q <= INIT_TABLE[e*CTR_W +: CTR_W];
        end else if (hit) begin
          if (wr_up) begin
            if (ctr_q != CTR_MAX) ctr_q <= ctr_q + CTR_W'(1);
          end else begin
            if (ctr_q != CTR_MIN) ctr_q <= ctr_q - CTR_W'(1);
          end
        end
      end

      assign tab_flat[e*CTR_W +: CTR_W] = ctr_q;
    end
  endgenerate

  assign rd_ctr = tab_flat[rd_idx*CTR_W +: CTR_W];
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int unsigned PC_W   = gshare_pkg::DEF_PC_W,
  parameter int unsigned PC_LSB = gshare_pkg::DEF_PC_LSB,
  parameter int unsigned HIST_W = gshare_pkg::DEF_HIST_W,
  parameter int unsigned CTR_W  = gshare_pkg::DEF_CTR_W,
  localparam int unsigned ENTRIES = 1 << HIST_W,
  parameter logic [ENTRIES*CTR_W-1:0] INIT_TABLE = {ENTRIES{2'b01}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_valid,
  output logic              lookup_ready,
  input  logic [PC_W-1:0]   lookup_pc,
  output logic              pred_valid,
  output logic [HIST_W-1:0] pred_idx,
  output logic [CTR_W-1:0]  pred_ctr,
  output logic              pred_taken,
  input  logic              train_valid,
  output logic              train_ready,
  input  logic [HIST_W-1:0] train_idx,
  input  logic              train_taken
);
  import gshare_pkg::*;

  logic [HIST_W-1:0]        hist_q;
  logic [ENTRIES*CTR_W-1:0] pht_flat;
  logic                     train_fire;
  dir_e                     pred_dir;

  assign lookup_ready = 1'b1;
  assign train_ready  = 1'b1;
  assign train_fire   = train_valid && train_ready;

  gshare_index #(
    .PC_W  (PC_W),
    .PC_LSB(PC_LSB),
    .HIST_W(HIST_W)
  ) u_index (
    .pc  (lookup_pc),
    .hist(hist_q),
    .idx (pred_idx)
  );

  gshare_history #(
    .HIST_W(HIST_W)
  ) u_history (
    .clk     (clk),
    .rst     (rst),
    .shift_en(train_fire),
    .outcome (train_taken),
    .hist_q  (hist_q)
  );

  gshare_pht #(
    .IDX_W     (HIST_W),
    .CTR_W     (CTR_W),
    .INIT_TABLE(INIT_TABLE)
  ) u_pht (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (train_fire),
    .wr_idx  (train_idx),
    .wr_up   (train_taken),
    .rd_idx  (pred_idx),
    .rd_ctr  (pred_ctr),
    .tab_flat(pht_flat)
  );

  assign pred_dir   = dir_e'(pred_ctr[CTR_W-1]);
  assign pred_taken = (pred_dir == DIR_TAKEN);
  assign pred_valid = lookup_valid && lookup_ready;
endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CTR_W  = 2,
  localparam int unsigned ENTRIES = 1 << HIST_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     lookup_ready,
  input logic                     train_ready,
  input logic                     train_valid,
  input logic [HIST_W-1:0]        train_idx,
  input logic                     train_taken,
  input logic [HIST_W-1:0]        hist,
  input logic [ENTRIES*CTR_W-1:0] pht_flat
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    train_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(train_taken)});

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !train_valid |=> $stable(hist) && $stable(pht_flat));

  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_ready && train_ready);

  // R3
  ctr_up_chk: assert property (@(posedge clk) disable iff (rst)
    (train_valid && train_taken && pht_flat[train_idx*CTR_W +: CTR_W] != CTR_MAX)
    |=> pht_flat[$past(train_idx)*CTR_W +: CTR_W] ==
        $past(pht_flat[train_idx*CTR_W +: CTR_W]) + CTR_W'(1));

  // R3
  ctr_top_chk: assert property (@(posedge clk) disable iff (rst)
    (train_valid && train_taken && pht_flat[train_idx*CTR_W +: CTR_W] == CTR_MAX)
    |=> pht_flat[$past(train_idx)*CTR_W +: CTR_W] == CTR_MAX);

  // R4
  ctr_down_chk: assert property (@(posedge clk) disable iff (rst)
    (train_valid && !train_taken && pht_flat[train_idx*CTR_W +: CTR_W] != '0)
    |=> pht_flat[$past(train_idx)*CTR_W +: CTR_W] ==
        $past(pht_flat[train_idx*CTR_W +: CTR_W]) - CTR_W'(1));

  // R4
  ctr_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (train_valid && !train_taken && pht_flat[train_idx*CTR_W +: CTR_W] == '0)
    |=> pht_flat[$past(train_idx)*CTR_W +: CTR_W] == '0);

  // R7
  hist_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> hist == '0);
endmodule

bind gshare_predictor gshare_checker #(
  .HIST_W(HIST_W),
  .CTR_W (CTR_W)
) u_gshare_chk (
  .clk         (clk),
  .rst         (rst),
  .lookup_ready(lookup_ready),
  .train_ready (train_ready),
  .train_valid (train_valid),
  .train_idx   (train_idx),
  .train_taken (train_taken),
  .hist        (hist_q),
  .pht_flat    (pht_flat)
);

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = {2'b11, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b01, 2'b10,
                                 2'b00, 2'b01, 2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 2'b10};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0;
  logic [15:0] lookup_pc = '0;
  logic        train_valid = 1'b0;
  logic [3:0]  train_idx = '0;
  logic        train_taken = 1'b0;

  logic       a_lrdy, a_pvld, a_ptk, a_trdy;
  logic [3:0] a_pidx;
  logic [1:0] a_pctr;
  logic       b_lrdy, b_pvld, b_ptk, b_trdy;
  logic [3:0] b_pidx;
  logic [1:0] b_pctr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mdl_a [16];
  int mdl_b [16];
  logic [3:0] mdl_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_predictor #(.INIT_TABLE(PAT)) i_gshare_predictor (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_ready(a_lrdy),
    .lookup_pc(lookup_pc), .pred_valid(a_pvld), .pred_idx(a_pidx), .pred_ctr(a_pctr),
    .pred_taken(a_ptk), .train_valid(train_valid), .train_ready(a_trdy),
    .train_idx(train_idx), .train_taken(train_taken)
  );

  gshare_predictor i_gshare_predictor_dflt (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_ready(b_lrdy),
    .lookup_pc(lookup_pc), .pred_valid(b_pvld), .pred_idx(b_pidx), .pred_ctr(b_pctr),
    .pred_taken(b_ptk), .train_valid(train_valid), .train_ready(b_trdy),
    .train_idx(train_idx), .train_taken(train_taken)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    train_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mdl_hist = '0;
    for (int e = 0; e < 16; e++) begin
      mdl_a[e] = int'(PAT[e*2 +: 2]);
      mdl_b[e] = 1;
    end
  endtask

  // Looks up entry e through the PC under the model history and checks both builds.
  task automatic look(input string req, input int e);
    lookup_valid = 1'b1;
    lookup_pc = {8'h5A, 4'(e) ^ mdl_hist, 4'h3};
    #1;
    chk({req, " idx"}, int'(a_pidx), e);
    chk({req, " ctrA"}, int'(a_pctr), mdl_a[e]);
    chk({req, " ctrB"}, int'(b_pctr), mdl_b[e]);
    chk({req, " takenA"}, int'(a_ptk), mdl_a[e] / 2);
    chk({req, " takenB"}, int'(b_ptk), mdl_b[e] / 2);
  endtask

  task automatic look_all(input string req);
    for (int e = 0; e < 16; e++) look(req, e);
  endtask

  function automatic int sat(input int v, input logic up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic train(input int idx, input logic tk);
    @(negedge clk);
    train_valid = 1'b1;
    train_idx = 4'(idx);
    train_taken = tk;
    @(negedge clk);
    train_valid = 1'b0;
    mdl_a[idx] = sat(mdl_a[idx], tk);
    mdl_b[idx] = sat(mdl_b[idx], tk);
    mdl_hist = {mdl_hist[2:0], tk};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: reset table contents for both builds; history 0 so idx equals pc nibble
    look_all("R7 reset table");
    #1;
    chk("R9 lookup_ready", int'(a_lrdy & b_lrdy), 1);
    chk("R9 train_ready", int'(a_trdy & b_trdy), 1);
    chk("R2 pred_valid follows", int'(a_pvld), 1);

    // R1: every PC nibble against every history value built by training index 0
    for (int h = 0; h < 16; h++) begin
      do_reset();
      for (int k = 3; k >= 0; k--) train(0, h[k]);
      chk("R5 history via idx", int'(mdl_hist), h);
      for (int n = 0; n < 16; n++) begin
        lookup_pc = {4'h9, 4'hC, 4'(n), 4'hF};
        #1;
        chk("R1 index xor", int'(a_pidx), n ^ h);
      end
    end

    // R1 R2: worked values with the irregular table
    do_reset(); train(0, 0); train(0, 1); train(0, 0); train(0, 1);
    lookup_pc = 16'h0124; #1;
    chk("R1 ex a idx", int'(a_pidx), 7);
    chk("R2 ex a ctr", int'(a_pctr), 0);
    chk("R2 ex a taken", int'(a_ptk), 0);
    do_reset(); train(0, 1); train(0, 0); train(0, 1); train(0, 0);
    lookup_pc = 16'h0124; #1;
    chk("R1 ex b idx", int'(a_pidx), 8);
    chk("R2 ex b ctr", int'(a_pctr), 2);
    chk("R2 ex b taken", int'(a_ptk), 1);
    do_reset(); train(0, 0); train(0, 1); train(0, 1); train(0, 1);
    lookup_pc = 16'h2588; #1;
    chk("R1 ex c idx", int'(a_pidx), 15);
    chk("R2 ex c ctr", int'(a_pctr), 3);
    chk("R2 ex c taken", int'(a_ptk), 1);

    // R3 R4 R8: saturate every entry up and then down, sweeping the table each step
    do_reset();
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 4; s++) begin
        train(e, 1);
        look("R3 up step", e);
      end
      for (int s = 0; s < 4; s++) begin
        train(e, 0);
        look("R4 down step", e);
      end
      look_all("R8 others unchanged");
    end

    // R6: same-cycle lookup and train on one entry return the old value
    do_reset();
    for (int e = 0; e < 16; e += 5) begin
      @(negedge clk);
      lookup_pc = {8'h00, 4'(e) ^ mdl_hist, 4'h0};
      train_valid = 1'b1;
      train_idx = 4'(e);
      train_taken = 1'b1;
      #1;
      chk("R6 pre-update ctrA", int'(a_pctr), mdl_a[e]);
      chk("R6 pre-update ctrB", int'(b_pctr), mdl_b[e]);
      @(negedge clk);
      train_valid = 1'b0;
      mdl_a[e] = sat(mdl_a[e], 1'b1);
      mdl_b[e] = sat(mdl_b[e], 1'b1);
      mdl_hist = {mdl_hist[2:0], 1'b1};
      look("R6 after edge", e);
    end

    // R9: idle cycles with noise on the training lines change nothing
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      train_valid = 1'b0;
      train_idx = 4'(c * 3);
      train_taken = c[0];
    end
    look_all("R9 idle ignored");

    // R7: reset after training restores history and table
    do_reset();
    look_all("R7 re-reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule